// File: doc/BRIEF.md
# Flow-Table Race and Stability Analyser

This block is a clocked model of a two-variable asynchronous sequential machine that has two inputs. Its excitation table is a parameter, fixed at elaboration. The block holds the machine's present total state, which is the pair of input value and state code. A caller offers a new input value with a one-cycle `start` pulse. The block then settles the machine one step per clock. At each step it follows every order in which the state bits could flip whenever more than one of them wants to change.

When the analysis ends, `done` pulses for one cycle and the verdict is updated. The verdict gives the stable state that is reached when y1 always flips first, and whether that state is valid. It also gives four flags: a race occurred, the race was critical, the machine oscillated, and the input change broke fundamental mode. The verdict then holds until the next analysis. The block is meant for checking a flow table's behaviour and for emulating it in a synchronous setting.

Top module: `flow_race_analyzer`

## Requirements
- R1: A synchronous active-high `rst` sets state 00, `state_valid`=1 and all four flags to 0. It also sets the stored input to 01, under which state 00 is stable.
- R2: State code is {y1,y2}. The default next state, per present state, for inputs 00/01/11/10 is: from 00 go 01,00,00,10; from 01 go 01,01,01,10; from 11 go 11,01,11,10; from 10 go 01,01,00,10. A total state is stable when the next state equals the present state. Each analysis settles to a stable state and reports it on `state_out` with `state_valid`=1.
- R3: `race` is 1 when, on some path during the analysis, a step needs both state bits to change at once.
- R4: When a race occurs, both single-bit orders are followed. `critical_race` is 1 when more than one distinct stable state can be reached. `state_out` is always the end of the path that flips y1 (the upper bit) first.
- R5: If some path is still unstable after 8 steps, `oscillation` is 1. `state_valid` is then 1 only if the y1-first path ended in a stable state.
- R6: `fm_violation` is 1 when both input bits differ from the stored input, or when the stored total state was not stable at `start`. The analysis still runs.
- R7: A `start` that arrives while an analysis is running is ignored. Each accepted `start` produces exactly one `done` pulse.
- R8: The verdict outputs change only in the cycle in which `done` is 1. Otherwise they hold, whatever `x_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: apply `x_in` as the new input |
| x_in | input | 2 | New input value {x1,x2} |
| done | output | 1 | One-cycle pulse when the verdict is updated |
| state_out | output | 2 | Final state {y1,y2}, y1-first path |
| state_valid | output | 1 | `state_out` is a stable state |
| race | output | 1 | A two-bit state change occurred |
| critical_race | output | 1 | More than one stable outcome is reachable |
| oscillation | output | 1 | A path did not settle within the step limit |
| fm_violation | output | 1 | The input change broke fundamental mode |

## Verification
A chain of input changes drives the default table through several kinds of settling. Some are plain single-step moves and some are multi-step walks. One is a race whose two orders converge on the same state, so only `race` may rise. Another, from 10 with input 00, has two orders that end in 01 and 11; it separates `critical_race` from `race` and confirms that the y1-first result, 01, is reported. Two-bit input jumps, a repeat of the same input and a busy-time `start` whose value would flip the violation check of the next analysis show whether the stored input is the right one. A second instance whose table has a four-state cycle in one column exercises oscillation and the not-stable violation that follows it.

// File: rtl/flowrace_pkg.sv
package flowrace_pkg;

    localparam int SW  = 2;               // state variables
    localparam int XW  = 2;               // input variables
    localparam int NST = 1 << SW;         // state codes
    localparam int NX  = 1 << XW;         // input codes
    localparam int TBW = NST * NX * SW;   // table width

    typedef logic [SW-1:0] code_t;
    typedef logic [XW-1:0] in_t;
    typedef logic [NST-1:0] set_t;

    // entry (s,x) sits at bits [(s*NX + x)*SW +: SW]; rows from s=11 down to s=00,
    // within a row x=11,10,01,00
    localparam logic [TBW-1:0] DEFAULT_TABLE =
        32'b11_10_01_11_00_10_01_01_01_10_01_01_00_10_00_01;

    localparam in_t   RESET_X     = 2'b01;
    localparam code_t RESET_STATE = 2'b00;
    localparam code_t Y1_MASK     = code_t'(1) << (SW - 1);

    typedef enum logic {PH_IDLE, PH_RUN} phase_t;

    typedef struct packed {
        code_t st;
        logic  valid;
        logic  race;
        logic  crit;
        logic  osc;
        logic  viol;
    } verdict_t;

    function automatic code_t lookup(input logic [TBW-1:0] tbl, input code_t s, input in_t x);
        return tbl[(int'(s) * NX + int'(x)) * SW +: SW];
    endfunction

    function automatic set_t onehot(input code_t c);
        return set_t'(1) << c;
    endfunction

    function automatic logic multi_bit(input code_t d);
        return (d & (d - code_t'(1))) != '0;
    endfunction

endpackage

// File: rtl/flow_set_expand.sv
module flow_set_expand
    import flowrace_pkg::*;
#(
    parameter logic [TBW-1:0] FLOW_TABLE = DEFAULT_TABLE
) (
    input  set_t         set_cur,
    input  in_t          x,
    output set_t         set_nxt,
    output logic         all_stable,
    output logic         race_now,
    output logic [SW:0]  stable_cnt
);
    set_t contrib [NST];
    set_t stable_vec;
    set_t multi_vec;

    for (genvar g = 0; g < NST; g++) begin : g_member
        localparam code_t ME = code_t'(g);
        code_t nx;
        code_t diff;
        assign nx   = lookup(FLOW_TABLE, ME, x);
        assign diff = nx ^ ME;
        assign stable_vec[g] = (diff == '0);
        assign multi_vec[g]  = multi_bit(diff);

        always_comb begin
            contrib[g] = '0;
            if (set_cur[g]) begin
                if (stable_vec[g]) begin
                    contrib[g] = onehot(ME);
                end else if (multi_vec[g]) begin
                    for (int b = 0; b < SW; b++) begin
                        if (diff[b]) contrib[g] = contrib[g] | onehot(ME ^ (code_t'(1) << b));
                    end
                end else begin
                    contrib[g] = onehot(nx);
                end
            end
        end
    end

    always_comb begin
        set_nxt    = '0;
        stable_cnt = '0;
        for (int i = 0; i < NST; i++) begin
            set_nxt = set_nxt | contrib[i];
            if (set_cur[i] && stable_vec[i]) stable_cnt = stable_cnt + 1'b1;
        end
    end

    assign all_stable = ~|(set_cur & ~stable_vec);
    assign race_now   = |(set_cur & multi_vec);

endmodule

// File: rtl/flow_primary_step.sv
module flow_primary_step
    import flowrace_pkg::*;
#(
    parameter logic [TBW-1:0] FLOW_TABLE = DEFAULT_TABLE
) (
    input  code_t cur,
    input  in_t   x,
    output code_t nxt,
    output logic  stable
);
    code_t target;
    code_t diff;

    assign target = lookup(FLOW_TABLE, cur, x);
    assign diff   = target ^ cur;
    assign stable = (diff == '0);

    always_comb begin
        if (multi_bit(diff) && diff[SW-1]) nxt = cur ^ Y1_MASK;
        else if (multi_bit(diff))          nxt = cur ^ (diff & (~diff + code_t'(1)));
        else                               nxt = target;
    end

endmodule

// File: rtl/fm_guard.sv
module fm_guard
    import flowrace_pkg::*;
(
    input  in_t  prev_x,
    input  in_t  new_x,
    input  logic settled,
    output logic violation
);
    in_t delta;
    assign delta     = prev_x ^ new_x;
    assign violation = !settled || ((delta & (delta - in_t'(1))) != '0);
endmodule

// File: rtl/flow_race_analyzer.sv
module flow_race_analyzer
    import flowrace_pkg::*;
#(
    parameter logic [TBW-1:0] FLOW_TABLE = DEFAULT_TABLE,
    parameter int             MAX_STEPS  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [XW-1:0] x_in,
    output logic          done,
    output logic [SW-1:0] state_out,
    output logic          state_valid,
    output logic          race,
    output logic          critical_race,
    output logic          oscillation,
    output logic          fm_violation
);
    localparam int CW = $clog2(MAX_STEPS + 1);
    localparam logic [CW-1:0] STEP_LIMIT = CW'(MAX_STEPS);

    phase_t      phase;
    in_t         cur_x, run_x;
    code_t       pres, prim_q, prim_nxt;
    logic        pres_ok, prim_stable;
    set_t        set_q, set_nxt;
    logic [CW-1:0] steps;
    logic        race_acc, viol_q, viol_now;
    logic        all_stable, race_now;
    logic [SW:0] stable_cnt;
    logic        finish_now;
    verdict_t    verdict;

    flow_set_expand #(.FLOW_TABLE(FLOW_TABLE)) u_expand (
        .set_cur    (set_q),
        .x          (run_x),
        .set_nxt    (set_nxt),
        .all_stable (all_stable),
        .race_now   (race_now),
        .stable_cnt (stable_cnt)
    );

    flow_primary_step #(.FLOW_TABLE(FLOW_TABLE)) u_primary (
        .cur    (prim_q),
        .x      (run_x),
        .nxt    (prim_nxt),
        .stable (prim_stable)
    );

    fm_guard u_guard (
        .prev_x    (cur_x),
        .new_x     (x_in),
        .settled   (pres_ok),
        .violation (viol_now)
    );

    assign finish_now = (phase == PH_RUN) && (all_stable || steps == STEP_LIMIT);

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            phase    <= PH_IDLE;
            cur_x    <= RESET_X;
            run_x    <= RESET_X;
            pres     <= RESET_STATE;
            pres_ok  <= 1'b1;
            set_q    <= '0;
            prim_q   <= RESET_STATE;
            steps    <= '0;
            race_acc <= 1'b0;
            viol_q   <= 1'b0;
            verdict  <= '{st: RESET_STATE, valid: 1'b1, race: 1'b0, crit: 1'b0, osc: 1'b0, viol: 1'b0};
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        run_x    <= x_in;
                        set_q    <= onehot(pres);
                        prim_q   <= pres;
                        steps    <= '0;
                        race_acc <= 1'b0;
                        viol_q   <= viol_now;
                        phase    <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (finish_now) begin
                        verdict <= '{st:    prim_q,
                                     valid: prim_stable,
                                     race:  race_acc,
                                     crit:  (stable_cnt > 1),
                                     osc:   !all_stable,
                                     viol:  viol_q};
                        done    <= 1'b1;
                        cur_x   <= run_x;
                        pres    <= prim_q;
                        pres_ok <= prim_stable;
                        phase   <= PH_IDLE;
                    end else begin
                        set_q    <= set_nxt;
                        prim_q   <= prim_nxt;
                        steps    <= steps + 1'b1;
                        race_acc <= race_acc | race_now;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign state_out     = verdict.st;
    assign state_valid   = verdict.valid;
    assign race          = verdict.race;
    assign critical_race = verdict.crit;
    assign oscillation   = verdict.osc;
    assign fm_violation  = verdict.viol;

endmodule

// File: rtl/flow_race_checker.sv
module flow_race_checker
    import flowrace_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic [SW-1:0] state_out,
    input logic          state_valid,
    input logic          race,
    input logic          critical_race,
    input logic          oscillation,
    input logic          fm_violation
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_out == '0 && state_valid && !race && !critical_race && !oscillation && !fm_violation));

    p_crit_implies_race_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && critical_race) |-> race);

    p_settled_is_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && !oscillation) |-> state_valid);

    p_single_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_verdict_r8: assert property (@(posedge clk) disable iff (rst)
        (armed && !done) |-> $stable({state_out, state_valid, race, critical_race, oscillation, fm_violation}));

endmodule

bind flow_race_analyzer flow_race_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .done          (done),
    .state_out     (state_out),
    .state_valid   (state_valid),
    .race          (race),
    .critical_race (critical_race),
    .oscillation   (oscillation),
    .fm_violation  (fm_violation)
);

// File: tb/sim_flow_race_analyzer.sv
module sim_flow_race_analyzer;
    import flowrace_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [TBW-1:0] OSC_TABLE =
        32'b10_10_01_11_00_10_01_01_11_10_01_01_01_10_00_01;
    localparam int NVEC = 11;
    // {x[1:0], state[1:0], valid, race, crit, osc, viol}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b00_01_1_0_0_0_0,
        9'b10_10_1_1_0_0_0,
        9'b00_01_1_1_1_0_0,
        9'b01_01_1_0_0_0_0,
        9'b11_01_1_0_0_0_0,
        9'b00_01_1_0_0_0_1,
        9'b10_10_1_1_0_0_0,
        9'b11_00_1_0_0_0_0,
        9'b01_00_1_0_0_0_0,
        9'b01_00_1_0_0_0_0,
        9'b00_01_1_0_0_0_0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start0 = 1'b0, start1 = 1'b0;
    logic [1:0] x = 2'b00;

    logic done0, valid0, race0, crit0, osc0, viol0;
    logic [1:0] st0;
    logic done1, valid1, race1, crit1, osc1, viol1;
    logic [1:0] st1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flow_race_analyzer u0 (
        .clk(clk), .rst(rst), .start(start0), .x_in(x), .done(done0),
        .state_out(st0), .state_valid(valid0), .race(race0),
        .critical_race(crit0), .oscillation(osc0), .fm_violation(viol0)
    );

    flow_race_analyzer #(.FLOW_TABLE(OSC_TABLE)) u1 (
        .clk(clk), .rst(rst), .start(start1), .x_in(x), .done(done1),
        .state_out(st1), .state_valid(valid1), .race(race1),
        .critical_race(crit1), .oscillation(osc1), .fm_violation(viol1)
    );

    function automatic logic [6:0] res0();
        return {st0, valid0, race0, crit0, osc0, viol0};
    endfunction
    function automatic logic [6:0] res1();
        return {st1, valid1, race1, crit1, osc1, viol1};
    endfunction

    task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic run(input int which, input logic [1:0] xv);
        int waited;
        @(negedge clk);
        x = xv;
        if (which == 0) start0 = 1'b1; else start1 = 1'b1;
        @(negedge clk);
        start0 = 1'b0;
        start1 = 1'b0;
        waited = 0;
        while (((which == 0) ? done0 : done1) !== 1'b1 && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 50) begin
            checks++;
            errors++;
            $display("FAIL R7: no done pulse, got 0 expected 1");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [6:0] held;
        int dones;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset verdict on both instances
        check("R1 reset u0", res0(), 7'b00_1_0_0_0_0);
        check("R1 reset u1", res1(), 7'b00_1_0_0_0_0);

        // R2/R3/R4/R6 vector walk on the default table
        for (int i = 0; i < NVEC; i++) begin
            run(0, VEC[i][8:7]);
            check($sformatf("R2/R3/R4/R6 vector %0d", i), res0(), VEC[i][6:0]);
        end

        // R1: stored input after reset is 01, so 10 is a two-bit jump (R6)
        do_reset();
        run(0, 2'b10);
        check("R1/R6 reset input 01", res0(), 7'b10_1_0_0_0_1);

        // R7: start while busy is ignored
        @(negedge clk);
        x = 2'b11;
        start0 = 1'b1;
        @(negedge clk);
        x = 2'b00;
        @(negedge clk);
        start0 = 1'b0;
        dones = 0;
        for (int c = 0; c < 30; c++) begin
            if (done0 === 1'b1) dones++;
            @(negedge clk);
        end
        check("R7 one done per accepted start", 7'(dones), 7'd1);
        check("R7 busy start ignored, verdict", res0(), 7'b00_1_0_0_0_0);
        // stored input must be 11, so 00 is a two-bit change
        run(0, 2'b00);
        check("R7/R6 stored input kept", res0(), 7'b01_1_0_0_0_1);

        // R8: verdict holds while x_in moves without start
        held = res0();
        x = 2'b10;
        repeat (5) @(negedge clk);
        x = 2'b11;
        repeat (3) @(negedge clk);
        check("R8 verdict held", res0(), held);

        // R5: oscillating column on u1
        run(1, 2'b11);
        check("R5 oscillation", res1(), 7'b00_0_0_0_1_0);
        run(1, 2'b01);
        check("R6 unstable start", res1(), 7'b00_1_0_0_0_1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule